// File: doc/BRIEF.md
# Rounded-Feedback First-Order Recursive Filter

This block is a single-pole recursive section for signed fixed-point samples. For each accepted sample it forms the next state from three steps. First it multiplies the previous output by a programmable coefficient. Then it rounds that product back to the data word's fractional precision. Finally it adds the new input sample and clamps the sum to the representable range. Because the feedback product is rounded to a short word, a decaying response does not always reach zero. It can settle on a small nonzero value, or on a value that flips sign every sample, and then hold there for as long as the input stays zero. This is the dead-band limit cycle.

A small detector watches for that condition. It raises a flag once the output magnitude has repeated across consecutive zero-input samples while the output is nonzero. Upstream logic presents a sample together with a strobe. One clock later the block returns the filtered sample together with its own strobe. The coefficient is read on the same edge as the sample, so it may be changed between samples.

Top module: `iir1_deadband`

## Requirements
- R1: A synchronous active-high reset clears the output sample to zero and deasserts both the output strobe and the stall flag.
- R2: The output strobe equals the input strobe delayed by one clock. The state advances only on a clock edge where the input strobe is high. On every other edge the output sample holds its value.
- R3: Samples are two's complement words of DATA_W bits with FRAC_W fractional bits. The coefficient is FRAC_W+1 bits: one sign bit and FRAC_W fractional bits, with |a| < 1. On each accepted sample the new output is sat(round(a*y_prev) + x).
- R4: The rounding adds half of one output LSB (2^(FRAC_W-1) in product units) to the full product and then drops the FRAC_W low bits with an arithmetic shift. Exact ties therefore go toward positive infinity. The rounded product lies within half an LSB of the exact product.
- R5: When the rounded sum exceeds the largest word (2^(DATA_W-1)-1), the output is that largest word. It does not wrap.
- R6: When the rounded sum is below the smallest word (-2^(DATA_W-1)), the output is that smallest word.
- R7: With a = 15/16, an impulse of 14/16 followed by zero input decays through 13/16, 12/16, 11/16, 10/16 and 9/16. It then stays at 8/16 (0.5), which is the dead-band bound of half an LSB divided by (1-|a|).
- R8: With a = -15/16, after an input of 8/16 followed by zero input, the output settles at a magnitude of 7/16. Its sign alternates on every sample.
- R9: The stall flag is set on an accepted sample when three conditions hold for both that sample and the one before it: the input is zero, the new output is nonzero, and the new output has the same magnitude as the previous output.
- R10: An accepted sample that breaks any condition of R9 clears the stall flag, including any nonzero input sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_x | input | DATA_W | Input sample, signed fixed point |
| coef_a | input | FRAC_W+1 | Feedback coefficient, sign plus FRAC_W fraction bits |
| out_valid | output | 1 | Output sample strobe |
| out_y | output | DATA_W | Filtered sample |
| stall_flag | output | 1 | Dead-band limit cycle detected |

## Verification
The bench targets exact rounding ties of both signs. A truncating design would let a 1/16 state collapse to zero, and a round-to-nearest-even design would give a different settled value. Repeated full-scale inputs of both polarities are applied so that a wrapping adder shows up as a sign flip on the output. The impulse decay with positive and with negative coefficients checks the settled values 0.5 and ±7/16. It also checks the cycle on which the flag rises, so a detector that compares signed values instead of magnitudes never flags the alternating case. Idle gaps between samples and a reset taken in the middle of a run catch state that drifts without a strobe or a flag that survives reset.

// File: rtl/iir1_pkg.sv
package iir1_pkg;
  // Progress of the detector through consecutive equal-magnitude,
  // zero-input samples.
  typedef enum logic [1:0] {
    RUN_NONE = 2'd0,
    RUN_ONE  = 2'd1,
    RUN_LOCK = 2'd2
  } stall_e;
endpackage

// File: rtl/iir1_round_mul.sv
// Feedback product a*y, rounded back to FRAC_W fractional bits
// (add half an LSB, then arithmetic shift).
module iir1_round_mul #(
  parameter int DATA_W = 10,
  parameter int FRAC_W = 4
) (
  input  logic signed [DATA_W-1:0] state_i,
  input  logic signed [FRAC_W:0]   coef_i,
  output logic signed [DATA_W:0]   rounded_o
);
  localparam int PROD_W = DATA_W + FRAC_W + 1;

  logic signed [PROD_W-1:0] prod;
  assign prod = state_i * coef_i;

  generate
    if (FRAC_W > 0) begin : g_round
      localparam int HALF = 1 << (FRAC_W - 1);
      logic signed [PROD_W-1:0] biased;
      // |prod| <= 2^(PROD_W-2), so adding HALF cannot overflow PROD_W bits.
      assign biased    = prod + $signed(PROD_W'(HALF));
      assign rounded_o = (DATA_W+1)'(biased >>> FRAC_W);
    end else begin : g_pass
      assign rounded_o = (DATA_W+1)'(prod);
    end
  endgenerate
endmodule

// File: rtl/iir1_sat_add.sv
// Adds the rounded feedback term to the input sample and clamps the result.
module iir1_sat_add #(
  parameter int DATA_W = 10
) (
  input  logic signed [DATA_W:0]   fb_i,
  input  logic signed [DATA_W-1:0] x_i,
  output logic signed [DATA_W-1:0] sum_o
);
  localparam int SUM_W = DATA_W + 2;
  localparam logic signed [SUM_W-1:0] MAX_W = SUM_W'((64'sd1 <<< (DATA_W-1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] MIN_W = -MAX_W - SUM_W'(1);

  logic signed [SUM_W-1:0] wide;
  assign wide = SUM_W'(fb_i) + SUM_W'(x_i);

  always_comb begin
    if (wide > MAX_W) begin
      sum_o = MAX_W[DATA_W-1:0];
    end else if (wide < MIN_W) begin
      sum_o = MIN_W[DATA_W-1:0];
    end else begin
      sum_o = wide[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/iir1_stall_det.sv
// Flags a state that keeps its magnitude under zero input.
module iir1_stall_det
  import iir1_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fire_i,
  input  logic                     x_zero_i,
  input  logic signed [DATA_W-1:0] y_new_i,
  input  logic signed [DATA_W-1:0] y_old_i,
  output logic                     flag_o
);
  function automatic logic [DATA_W-1:0] mag(input logic signed [DATA_W-1:0] v);
    // The most negative word maps to 2^(DATA_W-1), which still fits unsigned.
    return v[DATA_W-1] ? (~v + 1'b1) : v;
  endfunction

  logic   same_mag;
  logic   repeat_ok;
  stall_e run_q, run_d;

  assign same_mag  = (mag(y_new_i) == mag(y_old_i));
  assign repeat_ok = x_zero_i && (y_new_i != '0) && same_mag;

  always_comb begin
    run_d = run_q;
    if (fire_i) begin
      if (!repeat_ok) begin
        run_d = RUN_NONE;
      end else begin
        unique case (run_q)
          RUN_NONE: run_d = RUN_ONE;
          RUN_ONE:  run_d = RUN_LOCK;
          default:  run_d = RUN_LOCK;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= RUN_NONE;
    end else begin
      run_q <= run_d;
    end
  end

  assign flag_o = (run_q == RUN_LOCK);
endmodule

// File: rtl/iir1_deadband.sv
// First-order recursive section: y <= sat(round(a*y) + x) on each strobe.
module iir1_deadband #(
  parameter int DATA_W = 10,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_x,
  input  logic [FRAC_W:0]   coef_a,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_y,
  output logic              stall_flag
);
  logic signed [DATA_W-1:0] y_q;
  logic signed [DATA_W-1:0] y_next;
  logic signed [DATA_W:0]   fb_rounded;
  logic                     vld_q;
  logic                     x_zero;

  assign x_zero = (in_x == '0);

  iir1_round_mul #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_mul (
    .state_i   (y_q),
    .coef_i    ($signed(coef_a)),
    .rounded_o (fb_rounded)
  );

  iir1_sat_add #(.DATA_W(DATA_W)) u_add (
    .fb_i  (fb_rounded),
    .x_i   ($signed(in_x)),
    .sum_o (y_next)
  );

  iir1_stall_det #(.DATA_W(DATA_W)) u_det (
    .clk      (clk),
    .rst      (rst),
    .fire_i   (in_valid),
    .x_zero_i (x_zero),
    .y_new_i  (y_next),
    .y_old_i  (y_q),
    .flag_o   (stall_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        y_q <= y_next;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_y     = y_q;
endmodule

// File: rtl/iir1_deadband_chk.sv
module iir1_deadband_chk #(
  parameter int DATA_W = 10,
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_x,
  input logic [FRAC_W:0]   coef_a,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_y,
  input logic              stall_flag
);
  localparam longint MAXV  = (longint'(1) << (DATA_W-1)) - 1;
  localparam longint MINV  = -MAXV - 1;
  localparam longint SCALE = longint'(1) << FRAC_W;
  localparam longint HALF  = SCALE / 2;

  // Exact unrounded next value in product units.
  longint exact_l;
  assign exact_l = longint'($signed(coef_a)) * longint'($signed(out_y))
                 + longint'($signed(in_x)) * SCALE;

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_low_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_y));

  p_round_err_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && exact_l >= MINV * SCALE && exact_l <= MAXV * SCALE) |=>
    (((longint'($signed(out_y)) * SCALE - $past(exact_l)) > -HALF &&
      (longint'($signed(out_y)) * SCALE - $past(exact_l)) <= HALF) ||
     ((longint'($signed(out_y)) * SCALE - $past(exact_l)) == 0)));

  p_sat_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && exact_l >= (MAXV + 1) * SCALE - HALF) |=>
    (longint'($signed(out_y)) == MAXV));
  p_sat_lo_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && exact_l < MINV * SCALE - HALF) |=>
    (longint'($signed(out_y)) == MINV));

  p_flag_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    stall_flag |-> (out_y != '0));
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_x != '0) |=> !stall_flag);
endmodule

bind iir1_deadband iir1_deadband_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_x       (in_x),
  .coef_a     (coef_a),
  .out_valid  (out_valid),
  .out_y      (out_y),
  .stall_flag (stall_flag)
);

// File: tb/tb_iir1_deadband.sv
module tb_iir1_deadband;
  localparam int DW   = 10;
  localparam int FW   = 4;
  localparam int MAXV = (1 << (DW-1)) - 1;
  localparam int MINV = -(1 << (DW-1));
  localparam int HALF = 1 << (FW-1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_x = '0;
  logic [FW:0]   coef_a = '0;
  logic          out_valid;
  logic [DW-1:0] out_y;
  logic          stall_flag;

  iir1_deadband #(.DATA_W(DW), .FRAC_W(FW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .coef_a(coef_a),
    .out_valid(out_valid), .out_y(out_y), .stall_flag(stall_flag)
  );

  always #2 clk = ~clk;

  typedef struct { int y; bit flag; string tag; } exp_t;
  exp_t q[$];

  int  n_chk = 0;
  int  n_bad = 0;
  int  st = 0;
  int  run = 0;
  int  last_y = 0;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Reference recurrence built from R3..R6 and the flag rule of R9/R10.
  task automatic send(input int x, input int a, input string tag);
    int p, r, s;
    exp_t e;
    p = a * st;
    r = (p + HALF) >>> FW;
    s = r + x;
    if (s > MAXV) s = MAXV;
    if (s < MINV) s = MINV;
    if (x == 0 && s != 0 && iabs(s) == iabs(st)) run = (run < 2) ? run + 1 : 2;
    else run = 0;
    st = s;
    e.y = s; e.flag = (run == 2); e.tag = tag;
    q.push_back(e);
    in_valid = 1'b1;
    in_x     = DW'(x);
    coef_a   = (FW+1)'(a);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_x     = '0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2", "strobe with no pending sample", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(int'($signed(out_y)) == e.y, e.tag, "out_y", int'($signed(out_y)), e.y);
          chk(stall_flag == e.flag, e.tag, "stall_flag", int'(stall_flag), int'(e.flag));
          last_y = e.y;
        end
      end else begin
        chk(int'($signed(out_y)) == last_y, "R2", "hold without strobe",
            int'($signed(out_y)), last_y);
      end
    end
  end

  task automatic do_reset;
    rst = 1'b1;
    idle(3);
    chk(out_y == '0, "R1", "out_y in reset", int'(out_y), 0);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(stall_flag == 1'b0, "R1", "flag in reset", int'(stall_flag), 0);
    st = 0; run = 0; last_y = 0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R7: impulse decay into the positive dead band, a = 15/16
    send(14, 15, "R7");
    for (int i = 0; i < 10; i++) send(0, 15, "R7");
    idle(2);
    chk(int'($signed(out_y)) == 8, "R7", "settled dead-band value", int'($signed(out_y)), 8);
    chk(stall_flag == 1'b1, "R9", "flag after stall", int'(stall_flag), 1);

    // R10: nonzero input breaks the stall
    send(3, 15, "R10");
    idle(2);
    chk(stall_flag == 1'b0, "R10", "flag cleared by input", int'(stall_flag), 0);

    // R1: reset in the middle of a run
    do_reset();

    // R8: negative coefficient, alternating stuck state
    send(8, -15, "R8");
    for (int i = 0; i < 3; i++) send(0, -15, "R8");
    idle(1);
    chk(int'($signed(out_y)) == -7, "R8", "alternating state, negative phase",
        int'($signed(out_y)), -7);
    chk(stall_flag == 1'b1, "R9", "flag on alternating sign", int'(stall_flag), 1);
    send(0, -15, "R8");
    idle(1);
    chk(int'($signed(out_y)) == 7, "R8", "alternating state, positive phase",
        int'($signed(out_y)), 7);

    // R4: exact ties with a = 1/2 round toward +infinity
    do_reset();
    send(1, 8, "R4");
    send(0, 8, "R4");
    idle(1);
    chk(int'($signed(out_y)) == 1, "R4", "positive tie rounds up", int'($signed(out_y)), 1);
    send(-2, 8, "R4");
    send(0, 8, "R4");
    idle(1);
    chk(int'($signed(out_y)) == 0, "R4", "negative tie rounds up", int'($signed(out_y)), 0);

    // R5 / R6: saturation at both ends
    for (int i = 0; i < 3; i++) send(MAXV, 15, "R5");
    idle(1);
    chk(int'($signed(out_y)) == MAXV, "R5", "clamp high", int'($signed(out_y)), MAXV);
    for (int i = 0; i < 3; i++) send(MINV, 15, "R6");
    idle(1);
    chk(int'($signed(out_y)) == MINV, "R6", "clamp low", int'($signed(out_y)), MINV);

    // R3: mixed inputs and coefficients, with R2 gaps in between
    send(100, -6, "R3");
    send(-37, -6, "R3");
    idle(3);
    send(5, 11, "R3");
    send(0, 11, "R3");
    idle(2);
    send(200, -1, "R3");
    send(-150, 7, "R3");
    send(0, -16 + 1, "R3");
    idle(4);

    chk(q.size() == 0, "R2", "all samples returned", q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule